// File: doc/BRIEF.md
# Composite Video Level Rescaler

This block is a two-stage pipelined datapath that rescales 8-bit raw composite video samples on their way to a scaler, a data slicer or an output port. Each accepted sample is first re-centred on mid-code 128. The centred value is multiplied by a programmable gain counted in sixty-fourths, and the integer part of that product is kept. A programmable offset is then added, and the sum is saturated into the legal code range 1 to 254. This keeps codes 0 and 255 free for timing references.

Gain and offset sit in two 8-bit registers loaded through a one-cycle write port. After reset they hold 64 and 128, so the block passes every in-range sample through unchanged. With these defaults, sync bottom comes out at 1. Black comes out at 60, or at 71 for sources with a 7.5 IRE pedestal. White comes out at 199 or 209. A write affects only samples that arrive after it. A sample already inside the pipeline keeps the settings it entered with.

Top module: `vid_level_adj`

## Requirements
- R1: For an accepted sample X with gain G and offset O (both unsigned 8-bit), the output is clamp(trunc(G × (X − 128) / 64) + O), where trunc is the integer part.
- R2: After reset the gain is 64 and the offset is 128, so any sample X in 1..254 leaves the block as X.
- R3: Every output code lies in 1..254: results below 1 become 1, results above 254 become 254.
- R4: The integer part of a negative product is taken toward zero, not toward minus infinity. For example, G=32, O=128, X=127 gives 128.
- R5: out_valid is in_valid delayed by exactly two clock cycles. The matching result appears on out_sample in that same cycle, and back-to-back samples are accepted every cycle.
- R6: A write takes effect only for samples presented in later cycles. A sample presented in the same cycle as the write uses the old values. So does a sample already inside the pipeline, for both gain and offset.
- R7: With a gain of 0, every output equals the offset clamped to 1..254, whatever the input.
- R8: When cfg_we is 1 at a clock edge, cfg_wdata is stored into the gain if cfg_sel is 0, or into the offset if cfg_sel is 1. The other register keeps its value.
- R9: During and after reset, out_valid is 0 and out_sample is 1. While no result is delivered, out_sample holds its last value.
- R10: The intermediate product is wide enough that no value wraps at the extremes. For example, G=255 with X=0 gives 1, and G=255 with X=255 gives 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_sample as a sample to process |
| in_sample | input | 8 | Raw composite video sample, unsigned |
| cfg_we | input | 1 | Write strobe for the control registers |
| cfg_sel | input | 1 | Register select: 0 gain, 1 offset |
| cfg_wdata | input | 8 | Value to write |
| out_valid | output | 1 | Marks out_sample as a new result |
| out_sample | output | 8 | Rescaled and saturated sample |

## Verification
A stale gain or offset register shows up as a wrong code on the result of the first sample that follows the write. If the offset is not carried down the pipeline, the sample that was in flight during the write comes out wrong exactly two cycles after it entered. A rounding fault in the truncation step is hard to see. It shows only for negative products that are not multiples of 64, so the bench aims small gains at codes just under 128. A broken valid pipeline shows up at once as a result one cycle early or late, or as a missing or extra strobe.

// File: rtl/vla_pkg.sv
package vla_pkg;

    localparam int DW   = 8;
    localparam int GW   = 8;
    localparam int FRAC = 6;
    localparam int PW   = DW + GW + 2;
    localparam int QW   = PW - FRAC;
    localparam int SW   = QW + 1;
    localparam int MID  = 1 << (DW - 1);

    typedef enum logic {
        SEL_GAIN = 1'b0,
        SEL_OFS  = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic                 valid;
        logic signed [QW-1:0] q;
        logic [DW-1:0]        ofs;
    } stage1_t;

    function automatic logic signed [DW:0] center(input logic [DW-1:0] x);
        return $signed({1'b0, x}) - $signed((DW + 1)'(MID));
    endfunction

    // product / 2^FRAC, integer part taken toward zero
    function automatic logic signed [QW-1:0] scale_trunc(input logic signed [PW-1:0] p);
        logic signed [PW-1:0] bias;
        logic signed [PW-1:0] adj;
        bias = p[PW-1] ? $signed(PW'((1 << FRAC) - 1)) : $signed(PW'(0));
        adj  = p + bias;
        adj  = adj >>> FRAC;
        return adj[QW-1:0];
    endfunction

    function automatic logic [DW-1:0] saturate(input logic signed [SW-1:0] s,
                                               input int lo, input int hi);
        if (s < $signed(SW'(lo)))
            return DW'(lo);
        else if (s > $signed(SW'(hi)))
            return DW'(hi);
        else
            return s[DW-1:0];
    endfunction

endpackage

// File: rtl/vla_cfg_regs.sv
module vla_cfg_regs
    import vla_pkg::*;
#(
    parameter int GAIN_RST = 64,
    parameter int OFS_RST  = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  cfg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [GW-1:0] gain_q,
    output logic [DW-1:0] ofs_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GW'(GAIN_RST);
            ofs_q  <= DW'(OFS_RST);
        end else if (we) begin
            case (sel)
                SEL_GAIN: gain_q <= wdata[GW-1:0];
                SEL_OFS:  ofs_q  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/vla_scale_stage.sv
module vla_scale_stage
    import vla_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    input  logic [GW-1:0] gain,
    input  logic [DW-1:0] ofs,
    output stage1_t       s1
);

    logic signed [DW:0]    centred;
    logic signed [PW-1:0]  gain_x;
    logic signed [PW-1:0]  samp_x;
    logic signed [PW-1:0]  prod;
    logic signed [QW-1:0]  q_next;

    always_comb begin
        centred = center(in_sample);
        gain_x  = $signed({{(PW - GW){1'b0}}, gain});
        samp_x  = $signed({{(PW - DW - 1){centred[DW]}}, centred});
        prod    = gain_x * samp_x;
        q_next  = scale_trunc(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.q   <= q_next;
                s1.ofs <= ofs;   // offset travels with its sample
            end
        end
    end

endmodule

// File: rtl/vla_clamp_stage.sv
module vla_clamp_stage
    import vla_pkg::*;
#(
    parameter int LO = 1,
    parameter int HI = 254
) (
    input  logic          clk,
    input  logic          rst,
    input  stage1_t       s1,
    output logic          out_valid,
    output logic [DW-1:0] out_sample
);

    logic signed [SW-1:0] sum;

    always_comb begin
        sum = $signed({{(SW - QW){s1.q[QW-1]}}, s1.q})
            + $signed({{(SW - DW){1'b0}}, s1.ofs});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= DW'(LO);
        end else begin
            out_valid <= s1.valid;
            if (s1.valid)
                out_sample <= saturate(sum, LO, HI);
        end
    end

endmodule

// File: rtl/vid_level_adj.sv
module vid_level_adj
    import vla_pkg::*;
#(
    parameter int GAIN_RST = 64,
    parameter int OFS_RST  = 128,
    parameter int CODE_LO  = 1,
    parameter int CODE_HI  = 254
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_sample,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic       out_valid,
    output logic [7:0] out_sample
);

    logic [GW-1:0] gain_q;
    logic [DW-1:0] ofs_q;
    stage1_t       s1;
    cfg_sel_e      sel_e;

    assign sel_e = cfg_sel_e'(cfg_sel);

    vla_cfg_regs #(
        .GAIN_RST(GAIN_RST),
        .OFS_RST (OFS_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (sel_e),
        .wdata (cfg_wdata),
        .gain_q(gain_q),
        .ofs_q (ofs_q)
    );

    vla_scale_stage u_scale (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sample(in_sample),
        .gain     (gain_q),
        .ofs      (ofs_q),
        .s1       (s1)
    );

    vla_clamp_stage #(
        .LO(CODE_LO),
        .HI(CODE_HI)
    ) u_clamp (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1),
        .out_valid (out_valid),
        .out_sample(out_sample)
    );

endmodule

// File: rtl/vla_checks.sv
module vla_checks
    import vla_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 cfg_we,
    input logic [GW-1:0]        gain_q,
    input logic [DW-1:0]        ofs_q,
    input logic                 s1_valid,
    input logic signed [QW-1:0] s1_q,
    input logic                 out_valid,
    input logic [DW-1:0]        out_sample
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R3
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_sample >= 8'd1 && out_sample <= 8'd254);

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && gain_q == '0) |=> (s1_q == '0));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_sample));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(gain_q) && $stable(ofs_q)));

endmodule

bind vid_level_adj vla_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_we    (cfg_we),
    .gain_q    (gain_q),
    .ofs_q     (ofs_q),
    .s1_valid  (s1.valid),
    .s1_q      (s1.q),
    .out_valid (out_valid),
    .out_sample(out_sample)
);

// File: tb/vid_level_adj_test.sv
`timescale 1ns/1ps
module vid_level_adj_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       out_valid;
    logic [7:0] out_sample;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_gain = 64;
    int m_ofs = 128;
    bit done = 1'b0;

    typedef struct {
        int    exp;
        int    stamp;
        string req;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    vid_level_adj uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .out_valid (out_valid),
        .out_sample(out_sample)
    );

    function automatic int model(int x, int g, int o);
        int p;
        int s;
        p = g * (x - 128);
        s = p / 64 + o;       // integer division truncates toward zero
        if (s < 1)   s = 1;
        if (s > 254) s = 254;
        return s;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one cycle of stimulus; called just after a falling edge
    task automatic drive(bit v, int s, bit we, bit sel, int wd, string req);
        item_t it;
        in_valid  = v;
        in_sample = 8'(s);
        cfg_we    = we;
        cfg_sel   = sel;
        cfg_wdata = 8'(wd);
        if (v) begin
            it.exp   = model(s, m_gain, m_ofs);
            it.stamp = cyc;
            it.req   = req;
            sb.push_back(it);
        end
        if (we) begin
            if (sel) m_ofs = wd;
            else     m_gain = wd;
        end
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we   = 1'b0;
    endtask

    task automatic sample(int s, string req);
        drive(1'b1, s, 1'b0, 1'b0, 0, req);
    endtask

    task automatic write(bit sel, int wd);
        drive(1'b0, 0, 1'b1, sel, wd, "R8");
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 1'b0, 0, "");
    endtask

    // monitor: pops expected results as the design delivers them
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(int'(out_sample) == it.exp, it.req, int'(out_sample), it.exp);
                    check(cyc == it.stamp + 2, "R5 latency", cyc - it.stamp, 2);
                end
            end else if (sb.size() != 0 && sb[0].stamp + 2 == cyc) begin
                check(1'b0, "R5 missing out_valid", 0, 1);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        check(out_sample == 8'd1, "R9 reset out_sample", int'(out_sample), 1);
        rst = 1'b0;
        @(negedge clk);

        // R2 defaults transparent, R3 ends clamped
        sample(60, "R2");
        sample(71, "R2");
        sample(199, "R2");
        sample(209, "R2");
        sample(128, "R2");
        sample(1, "R2");
        sample(254, "R2");
        sample(0, "R3 low clamp");
        sample(255, "R3 high clamp");
        idle(3);

        // R8 register selection, R1 formula
        write(1'b0, 32);
        sample(200, "R8 gain write");
        sample(0, "R1");
        sample(129, "R1");
        sample(126, "R1");
        sample(127, "R4 trunc toward zero");
        write(1'b1, 40);
        sample(228, "R8 offset write");
        sample(28, "R1");
        idle(3);

        // R4 small gain, negative product below one step
        write(1'b0, 3);
        write(1'b1, 128);
        sample(127, "R4");
        sample(100, "R4");
        sample(120, "R4");
        idle(3);

        // R10 extreme gain
        write(1'b0, 255);
        sample(0, "R10");
        sample(255, "R10");
        sample(130, "R10");
        sample(125, "R10");
        idle(3);

        // R7 zero gain
        write(1'b0, 0);
        write(1'b1, 90);
        sample(0, "R7");
        sample(255, "R7");
        sample(37, "R7");
        write(1'b1, 0);
        sample(200, "R7 offset 0");
        write(1'b1, 255);
        sample(3, "R7 offset 255");
        idle(3);

        // R6 write timing
        write(1'b0, 64);
        write(1'b1, 128);
        drive(1'b1, 200, 1'b1, 1'b1, 20, "R6 same-cycle offset");
        sample(200, "R6 after offset write");
        drive(1'b1, 150, 1'b0, 1'b0, 0, "R6 in-flight offset");
        write(1'b1, 100);
        drive(1'b1, 150, 1'b1, 1'b0, 16, "R6 same-cycle gain");
        sample(150, "R6 after gain write");
        idle(3);

        // R5 back-to-back stream with changing settings
        for (int i = 0; i < 40; i++) begin
            if (i % 9 == 4)
                drive(1'b1, (i * 37 + 11) % 256, 1'b1, 1'b0, (i * 13) % 256, "R5 stream");
            else if (i % 11 == 7)
                drive(1'b1, (i * 37 + 11) % 256, 1'b1, 1'b1, (i * 29) % 256, "R5 stream");
            else
                sample((i * 37 + 11) % 256, "R5 stream");
        end
        idle(4);

        // R9 hold while idle
        held = int'(out_sample);
        idle(3);
        check(out_valid == 1'b0, "R9 idle out_valid", int'(out_valid), 0);
        check(int'(out_sample) == held, "R9 hold", int'(out_sample), held);

        check(sb.size() == 0, "R5 leftover items", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule